// File: doc/BRIEF.md
# Host Command Word Controller

This controller sits between two host-facing FIFOs and a small internal port bus. It takes 16-bit command words from a first-word-fall-through command FIFO and executes them. The opcode is in the upper byte and the argument is in the lower byte. A ping sends its own command word back through the response FIFO. An all-zero word does nothing. A port write takes a length word and then that many data words, and delivers them one by one to the addressed port. A port read takes a length word, fetches that many words from the addressed port, and queues them as responses.

Every transfer on the port bus is a strobe held until `port_ready_i` is high. A read returns its data in the same cycle as the acknowledgement. The controller holds a command, a data word or a read while the FIFO it needs is not in the right condition, or while the port is slow. Nothing is dropped or duplicated.

Top module: `hostcmd_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises, `cmd_pop_o`, `rsp_push_o`, `port_wr_o` and `port_rd_o` are all low until a command word is available. The controller then decodes the first word it sees as a command.
- R2: A word whose upper byte is 0x01 is a ping. It is popped, and the identical 16-bit word is pushed to the response FIFO in the same cycle.
- R3: The word 0x0000 is popped and produces no response and no port activity.
- R4: A word whose upper byte is not 0x01, 0x02 or 0x03 is popped and dropped like 0x0000. The word after it is decoded as a new command.
- R5: A word with upper byte 0x03 is followed by a length word N and then N data words. Each data word appears on `port_wdata_o` with `port_wr_o` high and `port_addr_o` equal to the command's lower byte. The words are delivered in the order they arrived.
- R6: A word with upper byte 0x02 is followed by a length word N. The controller then makes N reads on `port_rd_o` at the port named by the lower byte, and pushes each `port_rdata_i` value to the response FIFO in the cycle that read completes.
- R7: A length of 0 ends a read or write with no port strobe. The next word is decoded as a command.
- R8: `cmd_pop_o` is high only while `cmd_empty_i` is low.
- R9: `rsp_push_o` is high only while `rsp_full_i` is low. A ping that meets a full response FIFO is held without being popped.
- R10: While a port strobe waits for `port_ready_i`, the strobe, the address and the write data stay unchanged. No word is popped or pushed until the port accepts.
- R11: Responses leave in the order of the commands that produced them, including pings interleaved with no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_data_i | input | 16 | Head word of the command FIFO |
| cmd_empty_i | input | 1 | Command FIFO has no word |
| cmd_pop_o | output | 1 | Consume the head command word |
| rsp_data_o | output | 16 | Word pushed to the response FIFO |
| rsp_full_i | input | 1 | Response FIFO cannot accept a word |
| rsp_push_o | output | 1 | Push `rsp_data_o` |
| port_addr_o | output | 8 | Addressed internal port |
| port_wdata_o | output | 16 | Write data to the port |
| port_wr_o | output | 1 | Write strobe |
| port_rd_o | output | 1 | Read strobe |
| port_rdata_i | input | 16 | Read data, valid with `port_ready_i` |
| port_ready_i | input | 1 | Port accepts the current strobe |

## Verification
The properties assume both FIFOs behave like real FIFOs. The command FIFO's head word does not change and `cmd_empty_i` does not rise unless a pop takes place. `rsp_full_i` does not rise in a cycle without a push. The bench meets this by modelling the command FIFO as memory with pointers that only the pop moves. It raises its response-full control only while the controller is idle or holding a ping. Port readiness is throttled on alternate cycles without reference to the strobe, which the stall properties allow.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_NOP  = 8'h00;
  localparam logic [OP_W-1:0] OP_PING = 8'h01;
  localparam logic [OP_W-1:0] OP_RD   = 8'h02;
  localparam logic [OP_W-1:0] OP_WR   = 8'h03;

  typedef enum logic [1:0] {
    K_DROP,
    K_PING,
    K_RD,
    K_WR
  } cmd_kind_e;

  typedef enum logic [1:0] {
    S_DEC,
    S_LEN,
    S_WR,
    S_RD
  } ctrl_state_e;
endpackage

// File: rtl/hc_decode.sv
module hc_decode
  import hc_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic [DATA_W-1:0] word_i,
  output cmd_kind_e         kind_o
);
  logic [OP_W-1:0] op;
  assign op = word_i[DATA_W-1:ADDR_W];

  always_comb begin
    unique case (op)
      OP_PING: kind_o = K_PING;
      OP_RD:   kind_o = K_RD;
      OP_WR:   kind_o = K_WR;
      default: kind_o = K_DROP; // no-op and unknown opcodes
    endcase
  end
endmodule

// File: rtl/hc_beat_cnt.sv
module hc_beat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/hc_fsm.sv
module hc_fsm
  import hc_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_empty_i,
  input  cmd_kind_e         kind_i,
  input  logic              rsp_full_i,
  input  logic              port_ready_i,
  input  logic              last_i,
  output logic              cmd_pop_o,
  output logic              rsp_push_o,
  output logic              rsp_sel_port_o,
  output logic              port_wr_o,
  output logic              port_rd_o,
  output logic [ADDR_W-1:0] port_addr_o,
  output logic              cnt_load_o,
  output logic              cnt_dec_o
);
  ctrl_state_e st_q, st_d;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              latch;

  always_comb begin
    st_d           = st_q;
    cmd_pop_o      = 1'b0;
    rsp_push_o     = 1'b0;
    rsp_sel_port_o = 1'b0;
    port_wr_o      = 1'b0;
    port_rd_o      = 1'b0;
    cnt_load_o     = 1'b0;
    cnt_dec_o      = 1'b0;
    latch          = 1'b0;
    unique case (st_q)
      S_DEC: begin
        if (!cmd_empty_i) begin
          unique case (kind_i)
            K_PING: begin
              if (!rsp_full_i) begin
                cmd_pop_o  = 1'b1;
                rsp_push_o = 1'b1;
              end
            end
            K_RD, K_WR: begin
              cmd_pop_o = 1'b1;
              latch     = 1'b1;
              st_d      = S_LEN;
            end
            default: cmd_pop_o = 1'b1;
          endcase
        end
      end
      S_LEN: begin
        if (!cmd_empty_i) begin
          cmd_pop_o  = 1'b1;
          cnt_load_o = 1'b1;
          if (cmd_data_i == '0) st_d = S_DEC;
          else                  st_d = is_wr_q ? S_WR : S_RD;
        end
      end
      S_WR: begin
        port_wr_o = !cmd_empty_i;
        if (port_wr_o && port_ready_i) begin
          cmd_pop_o = 1'b1;
          cnt_dec_o = 1'b1;
          if (last_i) st_d = S_DEC;
        end
      end
      S_RD: begin
        port_rd_o = !rsp_full_i;
        if (port_rd_o && port_ready_i) begin
          rsp_push_o     = 1'b1;
          rsp_sel_port_o = 1'b1;
          cnt_dec_o      = 1'b1;
          if (last_i) st_d = S_DEC;
        end
      end
      default: st_d = S_DEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_DEC;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (latch) begin
        is_wr_q <= (kind_i == K_WR);
        addr_q  <= cmd_data_i[ADDR_W-1:0];
      end
    end
  end

  assign port_addr_o = addr_q;
endmodule

// File: rtl/hostcmd_ctrl.sv
module hostcmd_ctrl
  import hc_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_empty_i,
  output logic              cmd_pop_o,
  output logic [DATA_W-1:0] rsp_data_o,
  input  logic              rsp_full_i,
  output logic              rsp_push_o,
  output logic [ADDR_W-1:0] port_addr_o,
  output logic [DATA_W-1:0] port_wdata_o,
  output logic              port_wr_o,
  output logic              port_rd_o,
  input  logic [DATA_W-1:0] port_rdata_i,
  input  logic              port_ready_i
);
  cmd_kind_e kind;
  logic      last, cnt_load, cnt_dec, sel_port;

  hc_decode #(.ADDR_W(ADDR_W)) i_decode (
    .word_i (cmd_data_i),
    .kind_o (kind)
  );

  hc_beat_cnt #(.CNT_W(DATA_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cmd_data_i),
    .dec_i      (cnt_dec),
    .last_o     (last)
  );

  hc_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_data_i     (cmd_data_i),
    .cmd_empty_i    (cmd_empty_i),
    .kind_i         (kind),
    .rsp_full_i     (rsp_full_i),
    .port_ready_i   (port_ready_i),
    .last_i         (last),
    .cmd_pop_o      (cmd_pop_o),
    .rsp_push_o     (rsp_push_o),
    .rsp_sel_port_o (sel_port),
    .port_wr_o      (port_wr_o),
    .port_rd_o      (port_rd_o),
    .port_addr_o    (port_addr_o),
    .cnt_load_o     (cnt_load),
    .cnt_dec_o      (cnt_dec)
  );

  assign rsp_data_o   = sel_port ? port_rdata_i : cmd_data_i;
  assign port_wdata_o = cmd_data_i;
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              cmd_empty_i,
  input logic              cmd_pop_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              rsp_full_i,
  input logic              rsp_push_o,
  input logic [ADDR_W-1:0] port_addr_o,
  input logic [DATA_W-1:0] port_wdata_o,
  input logic              port_wr_o,
  input logic              port_rd_o,
  input logic [DATA_W-1:0] port_rdata_i,
  input logic              port_ready_i
);
  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pop_o |-> !cmd_empty_i);

  a_r9_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_push_o |-> !rsp_full_i);

  a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_wr_o && port_rd_o));

  a_r2_ping_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_push_o && !port_rd_o) |-> (cmd_pop_o && rsp_data_o == cmd_data_i));

  a_r5_write_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_o && port_ready_i) |-> (cmd_pop_o && port_wdata_o == cmd_data_i));

  a_r6_read_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_o && port_ready_i) |-> (rsp_push_o && rsp_data_o == port_rdata_i));

  a_r10_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_o && !port_ready_i) |=>
      (port_wr_o && $stable(port_addr_o) && $stable(port_wdata_o)));

  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_o && !port_ready_i) |=> (port_rd_o && $stable(port_addr_o)));

  a_r10_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((port_wr_o || port_rd_o) && !port_ready_i) |-> (!cmd_pop_o && !rsp_push_o));
endmodule

bind hostcmd_ctrl hc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_data_i   (cmd_data_i),
  .cmd_empty_i  (cmd_empty_i),
  .cmd_pop_o    (cmd_pop_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_full_i   (rsp_full_i),
  .rsp_push_o   (rsp_push_o),
  .port_addr_o  (port_addr_o),
  .port_wdata_o (port_wdata_o),
  .port_wr_o    (port_wr_o),
  .port_rd_o    (port_rd_o),
  .port_rdata_i (port_rdata_i),
  .port_ready_i (port_ready_i)
);

// File: tb/test_hostcmd_ctrl.sv
module test_hostcmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_data;
  logic        cmd_empty, cmd_pop;
  logic [15:0] rsp_data;
  logic        rsp_full, rsp_push;
  logic [7:0]  port_addr;
  logic [15:0] port_wdata, port_rdata;
  logic        port_wr, port_rd, port_ready;

  always #2.5 clk = ~clk;

  // command FIFO model
  logic [15:0] cmd_mem [256];
  logic [7:0]  cmd_wp = '0, cmd_rp = '0;
  assign cmd_empty = (cmd_wp == cmd_rp);
  assign cmd_data  = cmd_mem[cmd_rp];

  // response capture, port model
  logic [15:0] rsp_mem [256];
  int          rsp_cnt = 0;
  logic [7:0]  wr_addr [256];
  logic [15:0] wr_data [256];
  int          wr_cnt = 0, rd_cnt = 0, cyc = 0;
  logic        ready_mode = 1'b0, rsp_block = 1'b0;
  int          viol_pop = 0, viol_push = 0;

  assign port_ready = ready_mode ? cyc[0] : 1'b1;
  assign rsp_full   = rsp_block;
  assign port_rdata = {port_addr, rd_cnt[7:0]};

  hostcmd_ctrl i_hostcmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_data_i(cmd_data), .cmd_empty_i(cmd_empty), .cmd_pop_o(cmd_pop),
    .rsp_data_o(rsp_data), .rsp_full_i(rsp_full), .rsp_push_o(rsp_push),
    .port_addr_o(port_addr), .port_wdata_o(port_wdata),
    .port_wr_o(port_wr), .port_rd_o(port_rd),
    .port_rdata_i(port_rdata), .port_ready_i(port_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (cmd_pop) cmd_rp <= cmd_rp + 8'd1;
      if (cmd_pop && cmd_empty) viol_pop <= viol_pop + 1;
      if (rsp_push && rsp_full) viol_push <= viol_push + 1;
      if (rsp_push) begin
        rsp_mem[rsp_cnt[7:0]] <= rsp_data;
        rsp_cnt <= rsp_cnt + 1;
      end
      if (port_wr && port_ready) begin
        wr_addr[wr_cnt[7:0]] <= port_addr;
        wr_data[wr_cnt[7:0]] <= port_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (port_rd && port_ready) rd_cnt <= rd_cnt + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    cmd_mem[cmd_wp] = w;
    cmd_wp = cmd_wp + 8'd1;
  endtask

  task automatic drain(input int rsp_exp, input int wr_exp);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cmd_empty && rsp_cnt >= rsp_exp && wr_cnt >= wr_exp) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!cmd_pop && !rsp_push && !port_wr && !port_rd, "R1 strobes in reset",
          {cmd_pop, rsp_push, port_wr, port_rd}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cmd_pop && !rsp_push && !port_wr && !port_rd, "R1 idle after reset",
          {cmd_pop, rsp_push, port_wr, port_rd}, 0);
  endtask

  task automatic t_ping();
    int base = rsp_cnt;
    for (int i = 0; i < 10; i++) begin
      put(16'h0167 + 16'(i));
      put(16'h0000);
    end
    drain(base + 10, wr_cnt);
    check(rsp_cnt == base + 10, "R3 ping/no-op count", rsp_cnt - base, 10);
    for (int i = 0; i < 10; i++)
      check(rsp_mem[base + i] == 16'h0167 + 16'(i), "R2 R11 ping echo order",
            rsp_mem[base + i], 16'h0167 + i);
  endtask

  task automatic t_noop();
    int base = rsp_cnt;
    int wb = wr_cnt;
    for (int i = 0; i < 3; i++) put(16'h0000);
    drain(base, wb);
    check(rsp_cnt == base && wr_cnt == wb && cmd_empty, "R3 no-op silent",
          rsp_cnt - base, 0);
  endtask

  task automatic t_unknown();
    int base = rsp_cnt;
    put(16'h07AB);
    put(16'h00FF);
    put(16'hFF02);
    put(16'h0155);
    drain(base + 1, wr_cnt);
    check(rsp_cnt == base + 1, "R4 unknown dropped", rsp_cnt - base, 1);
    check(rsp_mem[base] == 16'h0155, "R4 resync", rsp_mem[base], 16'h0155);
  endtask

  task automatic t_write();
    logic [15:0] d[4] = '{16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hBABE};
    int wb = wr_cnt;
    int base = rsp_cnt;
    ready_mode = 1'b1;
    put(16'h0305);
    put(16'h0004);
    for (int i = 0; i < 4; i++) put(d[i]);
    put(16'h0181);
    drain(base + 1, wb + 4);
    ready_mode = 1'b0;
    check(wr_cnt == wb + 4, "R5 R10 write count", wr_cnt - wb, 4);
    for (int i = 0; i < 4; i++) begin
      check(wr_data[wb + i] == d[i], "R5 write data order", wr_data[wb + i], d[i]);
      check(wr_addr[wb + i] == 8'h05, "R5 write port", wr_addr[wb + i], 5);
    end
    check(rsp_cnt == base + 1 && rsp_mem[base] == 16'h0181, "R11 ping after write",
          rsp_mem[base], 16'h0181);
  endtask

  task automatic t_read();
    int base = rsp_cnt;
    int rb = rd_cnt;
    ready_mode = 1'b1;
    put(16'h0209);
    put(16'h0003);
    put(16'h0190);
    drain(base + 4, wr_cnt);
    ready_mode = 1'b0;
    check(rsp_cnt == base + 4, "R6 read response count", rsp_cnt - base, 4);
    for (int i = 0; i < 3; i++)
      check(rsp_mem[base + i] == {8'h09, 8'(rb + i)}, "R6 R10 read data",
            rsp_mem[base + i], {8'h09, 8'(rb + i)});
    check(rsp_mem[base + 3] == 16'h0190, "R11 ping after read", rsp_mem[base + 3], 16'h0190);
  endtask

  task automatic t_zero();
    int base = rsp_cnt;
    int wb = wr_cnt;
    int rb = rd_cnt;
    put(16'h0311);
    put(16'h0000);
    put(16'h0142);
    put(16'h0212);
    put(16'h0000);
    put(16'h0143);
    drain(base + 2, wb);
    check(wr_cnt == wb && rd_cnt == rb, "R7 zero length no strobe", wr_cnt - wb + rd_cnt - rb, 0);
    check(rsp_cnt == base + 2 && rsp_mem[base] == 16'h0142 && rsp_mem[base + 1] == 16'h0143,
          "R7 next word is command", rsp_mem[base + 1], 16'h0143);
  endtask

  task automatic t_full();
    int base = rsp_cnt;
    logic [7:0] rp0;
    @(negedge clk);
    rsp_block = 1'b1;
    put(16'h0177);
    rp0 = cmd_rp;
    repeat (10) @(negedge clk);
    check(cmd_rp == rp0 && rsp_cnt == base, "R9 ping held while full", rsp_cnt - base, 0);
    rsp_block = 1'b0;
    drain(base + 1, wr_cnt);
    check(rsp_cnt == base + 1 && rsp_mem[base] == 16'h0177, "R9 ping after release",
          rsp_mem[base], 16'h0177);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_ping();
    t_noop();
    t_unknown();
    t_write();
    t_read();
    t_zero();
    t_full();
    check(viol_pop == 0, "R8 pop only when non-empty", viol_pop, 0);
    check(viol_push == 0, "R9 push only when not full", viol_push, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule